// File: doc/BRIEF.md
# Ring Delay-Line Time-Domain Converter Back-End

This block is the digital half of a time-based analog-to-digital converter. An analog front end (not part of this block) drives a pulse front around a free-running ring of an even number of delay cells; the speed of the front follows the analog input, so a higher input sweeps more cells in each sample period. The back-end receives the cell tap outputs and a sample strobe, both in its own clock domain after the tap bus is passed through a two-flop synchronizer.

The back-end counts completed laps of the ring, converts each tap snapshot into a fine cell position, and on every strobe forms the total position (laps times cell count plus fine position). The conversion result is the distance the front covered since the previous strobe, taken modulo the span of the lap counter so that counter wraparound does no harm. Neither the ring nor the lap counter is ever cleared between conversions: the fractional remainder of one conversion is carried into the next, so the sum of consecutive codes equals the travelled distance exactly and the quantization error is first-order noise-shaped.

Top module: `ring_tdc_backend`

## Requirements
- R1: While `rst_n` is low at a clock edge, `conv_valid` and `conv_code` are 0 after that edge.
- R2: The first strobe accepted after reset produces no `conv_valid` pulse, because no earlier total exists.
- R3: `conv_valid` is high for exactly one clock, in the cycle after a strobe edge, for every strobe except the first after reset (back-to-back strobes give back-to-back pulses).
- R4: `conv_code` equals (total at this strobe minus total at the previous strobe) modulo `NUM_CELLS * 2**LAP_W`, where total = laps * `NUM_CELLS` + fine position.
- R5: Tap encoding: tap i is reported inverted when i is odd. After undoing that, for a front at phase p in 0..2*NUM_CELLS-1, cell i reads 1 when p < NUM_CELLS and i < p, or when p >= NUM_CELLS and i >= p - NUM_CELLS; the fine position is p mod NUM_CELLS.
- R6: One lap is counted each time the normalized value of the last cell (index NUM_CELLS-1) changes; the lap count moves by at most one per clock.
- R7: Nothing is cleared between conversions: the sum of all codes of a run equals the total travel between its first and last strobe, modulo the counter span.
- R8: Codes stay correct across wraparound of the lap counter.
- R9: A front that does not move between two strobes yields a code of 0.
- R10: A strobe sampled at clock edge k measures the tap state that was present at the input two clocks earlier (edge k-2), and the lap count of that same state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Back-end clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_taps | input | NUM_CELLS | Raw tap outputs of the ring, odd taps inverted |
| sample_strobe | input | 1 | Sample request, one clock wide per sample |
| conv_code | output | LAP_W + clog2(NUM_CELLS) | Distance travelled since the previous sample |
| conv_valid | output | 1 | One-clock pulse marking a new `conv_code` |

## Verification
The assertions watch, every cycle, that the normalized tap snapshot forms a single-edge ring pattern, that the lap count never jumps by more than one, that a result pulse only follows a strobe, that the first strobe after reset stays silent, and that reset clears the outputs. The arithmetic of the code itself, the two-clock sampling latency, the carry of the fractional remainder into the next conversion, a stationary front and the lap counter wraparound can only be shown by the bench, whose behavioural ring model tracks the absolute front position and compares every cycle.

// File: rtl/ring_tdc_pkg.sv
// Shared helpers for the ring delay-line converter back-end.
// Assumes the ring has at most 64 cells.
package ring_tdc_pkg;

    // Bit i set when cell i of an n-cell ring is reported inverted (odd cells).
    function automatic logic [63:0] odd_cell_mask(input int unsigned n);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            m[i] = (i < int'(n)) && (i % 2 == 1);
        end
        return m;
    endfunction

    // Bits needed to index n cells (at least one).
    function automatic int unsigned cell_index_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ring_tdc_sync.sv
// Two-flop synchronizer for the ring tap bus.
// Assumes each tap is individually safe to resynchronize; the reset value is
// chosen by the parent so that it reads as a front at phase zero.
module ring_tdc_sync #(
    parameter int unsigned          WIDTH   = 16,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    // Shift the raw taps through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/ring_tdc_lap_counter.sv
// Counts completed laps of the ring from the normalized last cell.
// The last cell changes value exactly once per lap, alternating polarity,
// so every change is one lap. Assumes the front moves fewer than a lap per clock.
// lap_now is the count that belongs to the current synchronized snapshot.
module ring_tdc_lap_counter #(
    parameter int unsigned LAP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_cell,
    output logic [LAP_W-1:0] lap_now
);

    logic             prev_cell;
    logic [LAP_W-1:0] lap_cnt;
    logic             lap_step;

    // A change of the last cell since the previous clock closes one lap.
    always_comb begin
        lap_step = (last_cell != prev_cell);
        lap_now  = lap_cnt + LAP_W'(lap_step);
    end

    // Remember the last cell and accumulate laps, wrapping freely.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cell <= 1'b0;
            lap_cnt   <= '0;
        end else begin
            prev_cell <= last_cell;
            lap_cnt   <= lap_now;
        end
    end

    // R6
    lap_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lap_cnt != $past(lap_cnt)) |-> (lap_cnt == $past(lap_cnt) + LAP_W'(1)));

endmodule

// File: rtl/ring_tdc_fine_encoder.sv
// Converts a normalized ring snapshot into the fine cell position.
// Assumes the snapshot holds at most one edge between neighbouring cells:
// the position is the lowest index whose cell differs from cell 0, or 0
// when all cells agree (front at the start of a lap).
module ring_tdc_fine_encoder #(
    parameter int unsigned NUM_CELLS = 16,
    parameter int unsigned IDX_W     = 4
) (
    input  logic [NUM_CELLS-1:0] norm_cells,
    output logic [IDX_W-1:0]     fine_pos
);

    // Scan downward so that the lowest differing index wins.
    always_comb begin
        fine_pos = '0;
        for (int i = NUM_CELLS - 1; i >= 1; i--) begin
            if (norm_cells[i] != norm_cells[0]) begin
                fine_pos = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ring_tdc_code_diff.sv
// Holds the total position of the previous sample and issues the difference
// to the current total, modulo MODV. The first sample after reset only
// primes the stored total. Assumes totals are already reduced below MODV.
module ring_tdc_code_diff #(
    parameter int unsigned TOT_W = 16,
    parameter logic [TOT_W:0] MODV = (TOT_W+1)'(1) << TOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [TOT_W-1:0] total_now,
    output logic [TOT_W-1:0] code,
    output logic             code_valid
);

    logic [TOT_W-1:0] prev_total;
    logic             have_prev;
    logic [TOT_W:0]   delta_ext;

    // Modular difference of the current and stored totals.
    always_comb begin
        if (total_now >= prev_total) begin
            delta_ext = {1'b0, total_now} - {1'b0, prev_total};
        end else begin
            delta_ext = {1'b0, total_now} + MODV - {1'b0, prev_total};
        end
    end

    // On a strobe, store the total and emit the difference when one exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_total <= '0;
            have_prev  <= 1'b0;
            code       <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= strobe && have_prev;
            if (strobe) begin
                prev_total <= total_now;
                have_prev  <= 1'b1;
                code       <= delta_ext[TOT_W-1:0];
            end
        end
    end

    // R2
    first_sample_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !have_prev) |=> !code_valid);

    // R3
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(strobe));

    // R7
    total_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe) |-> $stable(prev_total));

endmodule

// File: rtl/ring_tdc_backend.sv
// Digital back-end of a ring delay-line time-domain converter.
// Synchronizes the tap bus, undoes the odd-cell inversion of the ring,
// encodes the fine position, counts laps, and on each strobe outputs the
// distance travelled since the previous strobe. Nothing is cleared between
// conversions, so the fractional remainder carries into the next result.
// Assumes NUM_CELLS is even, 8..64, and the front moves less than a lap per clock.
module ring_tdc_backend
    import ring_tdc_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 16,
    parameter int unsigned LAP_W     = 12,
    localparam int unsigned IDX_W    = cell_index_bits(NUM_CELLS),
    localparam int unsigned TOT_W    = LAP_W + IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CELLS-1:0] ring_taps,
    input  logic                 sample_strobe,
    output logic [TOT_W-1:0]     conv_code,
    output logic                 conv_valid
);

    localparam logic [63:0]          MASK64   = odd_cell_mask(NUM_CELLS);
    localparam logic [NUM_CELLS-1:0] INV_MASK = MASK64[NUM_CELLS-1:0];
    localparam logic [TOT_W:0]       MODV     = (TOT_W+1)'(NUM_CELLS) << LAP_W;

    logic [NUM_CELLS-1:0] sync_taps;
    logic [NUM_CELLS-1:0] norm_cells;
    logic [IDX_W-1:0]     fine_pos;
    logic [LAP_W-1:0]     lap_now;
    logic [TOT_W-1:0]     total_now;
    logic [NUM_CELLS-2:0] cell_edges;

    // Bring the taps into the clock domain; reset reads as phase zero.
    ring_tdc_sync #(
        .WIDTH   (NUM_CELLS),
        .RST_VAL (INV_MASK)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ring_taps),
        .q     (sync_taps)
    );

    // Undo the inversion of the odd cells and combine laps and fine position.
    always_comb begin
        norm_cells = sync_taps ^ INV_MASK;
        cell_edges = norm_cells[NUM_CELLS-1:1] ^ norm_cells[NUM_CELLS-2:0];
        total_now  = TOT_W'(lap_now) * TOT_W'(NUM_CELLS) + TOT_W'(fine_pos);
    end

    ring_tdc_fine_encoder #(
        .NUM_CELLS (NUM_CELLS),
        .IDX_W     (IDX_W)
    ) u_fine (
        .norm_cells (norm_cells),
        .fine_pos   (fine_pos)
    );

    ring_tdc_lap_counter #(
        .LAP_W (LAP_W)
    ) u_laps (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_cell (norm_cells[NUM_CELLS-1]),
        .lap_now   (lap_now)
    );

    ring_tdc_code_diff #(
        .TOT_W (TOT_W),
        .MODV  (MODV)
    ) u_diff (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (sample_strobe),
        .total_now  (total_now),
        .code       (conv_code),
        .code_valid (conv_valid)
    );

    // R5
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cell_edges) <= 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!conv_valid && conv_code == '0));

endmodule

// File: tb/tb_ring_tdc_backend.sv
// Bench: a behavioural ring model tracks the absolute front position per
// clock, builds the tap pattern, and predicts every output cycle by cycle.
module tb_ring_tdc_backend;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 16;
    localparam int LAPW  = 12;
    localparam int TOTW  = LAPW + $clog2(N);
    localparam int MODV  = N << LAPW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ring_taps;
    logic            sample_strobe = 1'b0;
    logic [TOTW-1:0] conv_code;
    logic            conv_valid;

    int checks = 0;
    int fails  = 0;

    // Ring model state.
    int pos = 0, pm1 = 0, pm2 = 0;
    int prev_tot = 0;
    bit have_prev = 0;
    bit exp_valid = 0;
    int exp_code = 0;
    string exp_tag = "R3";
    string phase_tag = "R5";
    int first_tot = 0;
    int last_tot = 0;
    int code_sum = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_tdc_backend #(.NUM_CELLS(N), .LAP_W(LAPW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ring_taps     (ring_taps),
        .sample_strobe (sample_strobe),
        .conv_code     (conv_code),
        .conv_valid    (conv_valid)
    );

    function automatic int modm(input int x);
        return ((x % MODV) + MODV) % MODV;
    endfunction

    // Raw tap pattern of a front at absolute position p.
    function automatic logic [N-1:0] taps_of(input int p);
        logic [N-1:0] t;
        int ph;
        ph = p % (2 * N);
        for (int i = 0; i < N; i++) begin
            bit c;
            c = (ph < N) ? (i < ph) : (i >= ph - N);
            t[i] = c ^ (i % 2 == 1);
        end
        return t;
    endfunction

    // One clock: check the result of the previous edge, then drive the next inputs.
    task automatic step(input int speed, input bit stb);
        @(negedge clk);
        checks++;
        if (conv_valid !== exp_valid) begin
            fails++;
            $display("FAIL R3 valid: actual %0b expected %0b", conv_valid, exp_valid);
        end
        if (exp_valid) begin
            checks++;
            code_sum = code_sum + int'(conv_code);
            if (int'(conv_code) != exp_code) begin
                fails++;
                $display("FAIL %s/R4 code: actual %0d expected %0d", exp_tag, conv_code, exp_code);
            end
        end
        pm2 = pm1;
        pm1 = pos;
        pos = pos + speed;
        ring_taps = taps_of(pos);
        sample_strobe = stb;
        if (stb) begin
            int cur;
            cur = modm(pm2);
            exp_valid = have_prev;
            exp_code = modm(cur - prev_tot);
            exp_tag = have_prev ? phase_tag : "R2";
            if (!have_prev) first_tot = pm2;
            last_tot = pm2;
            prev_tot = cur;
            have_prev = 1;
        end else begin
            exp_valid = 0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        ring_taps = taps_of(0);
        // R1: outputs quiet while reset is held.
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (conv_valid !== 1'b0 || conv_code !== '0) begin
                fails++;
                $display("FAIL R1 reset: actual valid %0b code %0d expected 0 0", conv_valid, conv_code);
            end
        end
        rst_n = 1'b1;

        // R5/R6: steady motion over many laps; first strobe covers R2.
        phase_tag = "R5/R6";
        for (int c = 0; c < 400; c++) step(2, (c % 8) == 3);

        // R9: stationary front.
        phase_tag = "R9";
        for (int c = 0; c < 60; c++) step(0, (c % 6) == 5);

        // R10: speed changing every clock exposes the sampling latency.
        phase_tag = "R10";
        for (int c = 0; c < 600; c++) step((c % 4) + ((c % 7) == 0 ? 1 : 0), ((c % 12) == 4) || ((c % 12) == 9));

        // R3: back-to-back strobes.
        phase_tag = "R3";
        for (int c = 0; c < 20; c++) step(1, 1'b1);
        step(1, 1'b0);

        // R8: long run past the lap counter wrap.
        phase_tag = "R8";
        for (int c = 0; c < 22600; c++) step(3, (c % 13) == 6);
        step(0, 1'b0);
        step(0, 1'b0);

        // R7: sum of all codes equals the travel between first and last strobe.
        checks++;
        if (modm(code_sum) != modm(last_tot - first_tot)) begin
            fails++;
            $display("FAIL R7 sum: actual %0d expected %0d", modm(code_sum), modm(last_tot - first_tot));
        end
        // R8: the run must have actually wrapped the counter span.
        checks++;
        if (pos <= MODV) begin
            fails++;
            $display("FAIL R8 travel: actual %0d expected above %0d", pos, MODV);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule